// File: doc/BRIEF.md
# Programmable Reference Clock Generator

This block derives a reference clock from one input clock. A 3-bit ratio code picks a division of the input frequency by a power of two between 1 and 128. A 2-bit high-time code makes the output high for none, a quarter, a half or three quarters of each output period. Both codes are taken into internal settings only while the block is disabled, so a running output is never reshaped part-way through a period.

Turning the block on starts the output on a period boundary, so the first high pulse has its full length. Turning it off pulls the output low at once, through a gate that needs no clock edge. A hold input freezes the block: no counter or setting moves and the output level stays constant until hold is released, after which the sequence carries on from where it stopped.

Top module: `refclk_gen`

## Requirements
- R1: With stored ratio code k from 1 to 7, the output repeats every 2^k input clock cycles. It changes only on input clock edges, and each period begins on a rising input edge.
- R2: With ratio code k of 1 or more and stored high-time code d, the output is high for the first (2^k * d)/2 half input cycles of each period. Code 0 holds the output low, 1 gives 25%, 2 gives 50% and 3 gives 75%.
- R3: With ratio code 0 the output copies the input clock while enabled, and the high-time code has no effect.
- R4: With ratio code 1 and high-time code 1 or 3, the output is high for one or three half input cycles, using the falling input edge.
- R5: Reset is synchronous and active high. It drives the output low and sets the stored codes to ratio code 1 and high-time code 2 (50%). These values are used if enable is already high when reset ends.
- R6: The ratio and high-time inputs are copied into the stored codes at each rising input edge where enable and hold are both low. Changes made while enable is high have no effect until enable has been low at a rising edge.
- R7: When enable is first seen high at a rising input edge, the period counter starts from zero and the output rises on that edge with its full high time. No shortened pulse comes before it.
- R8: While enable is low the output is low. The output falls as soon as enable falls, without waiting for a clock edge.
- R9: Hold is sampled on rising input edges. While it is high, no counter, stored code or output register changes, and the divided output keeps the level it had just before the sampling edge. In ratio code 0 the output stays low from the next input cycle. After release the period continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; low forces the output low at once |
| div_sel | input | 3 | Ratio code: output period is 2^div_sel input cycles |
| duty_sel | input | 2 | High-time code: 0 low, 1 25%, 2 50%, 3 75% |
| hold | input | 1 | Freezes all state and the output level |
| ref_clk | output | 1 | Generated reference clock |

## Verification
A wrong period count shows on the output within one output period, as a high or low run of the wrong length. A stored code that was captured when it should not have been changes the run lengths in the next period after the change. A bad falling-edge register in the divide-by-two modes shows within one input cycle as a missing or extra half-cycle of high time. A hold that lets state creep forward shows as soon as hold is released, because the period then resumes at the wrong phase. Comparing the output at both half-cycles of every input cycle catches all of these within one output period.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int DUTY_W = 2;

  typedef enum logic [DUTY_W-1:0] {
    DUTY_OFF  = 2'b00,
    DUTY_Q1   = 2'b01,
    DUTY_HALF = 2'b10,
    DUTY_Q3   = 2'b11
  } duty_e;

  localparam logic [DUTY_W-1:0] DUTY_RST = DUTY_HALF;
endpackage

// File: rtl/refclk_cfg.sv
module refclk_cfg
  import refclk_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int RST_DIV = 1
) (
  input  logic              clk_in,
  input  logic              rst,
  input  logic              enable,
  input  logic              hold,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [DUTY_W-1:0] duty_sel,
  output logic [DIV_W-1:0]  cfg_div,
  output logic [DUTY_W-1:0] cfg_duty
);
  // settings move only while the generator is stopped and not frozen
  always_ff @(posedge clk_in) begin
    if (rst) begin
      cfg_div  <= DIV_W'(RST_DIV);
      cfg_duty <= DUTY_RST;
    end else if (!enable && !hold) begin
      cfg_div  <= div_sel;
      cfg_duty <= duty_sel;
    end
  end
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
  import refclk_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int CNT_W = (1 << DIV_W) - 1
) (
  input  logic              clk_in,
  input  logic              rst,
  input  logic              enable,
  input  logic              hold,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DUTY_W-1:0] cfg_duty,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pos_o,
  output logic              div_clk
);
  localparam int HW = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic             pos_q, nxt_q, neg_q, hold_q;
  logic [HW-1:0]    ratio, high_len, ratio_m1;
  logic [CNT_W-1:0] last_idx;
  logic             half_sel;

  always_comb begin
    ratio    = HW'(1) << cfg_div;
    high_len = (ratio * HW'(cfg_duty)) >> 1;
    ratio_m1 = ratio - HW'(1);
    last_idx = ratio_m1[CNT_W-1:0];
    half_sel = (cfg_div == DIV_W'(1)) && cfg_duty[0];
  end

  always_ff @(posedge clk_in) begin
    if (rst) begin
      cnt_q  <= '0;
      pos_q  <= 1'b0;
      nxt_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold;
      if (hold) begin
        pos_q <= neg_q;
      end else if (!enable) begin
        cnt_q <= '0;
        pos_q <= 1'b0;
        nxt_q <= 1'b0;
      end else begin
        pos_q <= HW'({cnt_q, 1'b0}) < high_len;
        nxt_q <= HW'({cnt_q, 1'b1}) < high_len;
        cnt_q <= (cnt_q == last_idx) ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  // second half of each input cycle, used only for odd half-cycle lengths
  always_ff @(negedge clk_in) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= hold_q ? pos_q : nxt_q;
  end

  assign div_clk = half_sel ? (clk_in ? pos_q : neg_q) : pos_q;
  assign cnt_o   = cnt_q;
  assign pos_o   = pos_q;
endmodule

// File: rtl/refclk_bypass.sv
module refclk_bypass (
  input  logic clk_in,
  input  logic rst,
  input  logic enable,
  input  logic hold,
  output logic byp_clk
);
  logic run_q, hold_q, gate_l;

  always_ff @(posedge clk_in) begin
    if (rst) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold;
      if (!hold) run_q <= enable;
    end
  end

  // open only during the low phase, so the gate never clips a high phase
  always_latch begin
    if (!clk_in) gate_l = run_q & ~hold_q;
  end

  assign byp_clk = clk_in & gate_l;
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
  import refclk_pkg::*;
#(
  parameter int DIV_W   = 3,
  parameter int RST_DIV = 1
) (
  input  logic              clk_in,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [DUTY_W-1:0] duty_sel,
  input  logic              hold,
  output logic              ref_clk
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0]  cfg_div;
  logic [DUTY_W-1:0] cfg_duty;
  logic [CNT_W-1:0]  div_cnt;
  logic              div_pos, div_clk, byp_clk, src_clk;

  refclk_cfg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cfg (
    .clk_in(clk_in), .rst(rst), .enable(enable), .hold(hold),
    .div_sel(div_sel), .duty_sel(duty_sel),
    .cfg_div(cfg_div), .cfg_duty(cfg_duty)
  );

  refclk_divider #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_div (
    .clk_in(clk_in), .rst(rst), .enable(enable), .hold(hold),
    .cfg_div(cfg_div), .cfg_duty(cfg_duty),
    .cnt_o(div_cnt), .pos_o(div_pos), .div_clk(div_clk)
  );

  refclk_bypass u_byp (
    .clk_in(clk_in), .rst(rst), .enable(enable), .hold(hold),
    .byp_clk(byp_clk)
  );

  assign src_clk = (cfg_div == '0) ? byp_clk : div_clk;
  assign ref_clk = enable & src_clk;
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk #(
  parameter int DIV_W = 3,
  parameter int CNT_W = 7
) (
  input logic             clk_in,
  input logic             rst,
  input logic             enable,
  input logic             hold,
  input logic             ref_clk,
  input logic [DIV_W-1:0] cfg_div,
  input logic [1:0]       cfg_duty,
  input logic [CNT_W-1:0] div_cnt,
  input logic             div_pos
);
  // R8
  disabled_low_chk: assert property (@(posedge clk_in) disable iff (rst)
    !enable |-> !ref_clk);

  // R6
  cfg_frozen_chk: assert property (@(posedge clk_in) disable iff (rst)
    enable |=> ($stable(cfg_div) && $stable(cfg_duty)));

  // R9
  hold_freeze_chk: assert property (@(posedge clk_in) disable iff (rst)
    hold |=> $stable(div_cnt));

  // R1
  cnt_range_chk: assert property (@(posedge clk_in) disable iff (rst)
    (int'(div_cnt) < (1 << cfg_div)));

  // R2
  duty_off_chk: assert property (@(posedge clk_in) disable iff (rst)
    (cfg_duty == 2'b00) |-> !div_pos);

  // R7
  start_zero_chk: assert property (@(posedge clk_in) disable iff (rst)
    (enable && !$past(enable) && !$past(hold)) |-> (div_cnt == '0));
endmodule

bind refclk_gen refclk_gen_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk_in(clk_in), .rst(rst), .enable(enable), .hold(hold),
  .ref_clk(ref_clk), .cfg_div(cfg_div), .cfg_duty(cfg_duty),
  .div_cnt(div_cnt), .div_pos(div_pos)
);

// File: tb/refclk_gen_tb.sv
`timescale 1ns/1ps
module refclk_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       hold = 1'b0;
  logic [2:0] div_sel = 3'd1;
  logic [1:0] duty_sel = 2'd2;
  wire        ref_clk;

  int    vec = 0;
  int    bad = 0;
  string tag = "R5";
  bit    chk_on = 1'b0;

  // reference model state
  int m_div = 1, m_duty = 2, ph = 0, n_len = 1, h_len = 0;
  bit f_lvl = 0, s_lvl = 0, run = 0, g_now = 0, g_first = 0;

  always #5 clk = ~clk;

  refclk_gen u_dut (
    .clk_in(clk), .rst(rst), .enable(enable), .div_sel(div_sel),
    .duty_sel(duty_sel), .hold(hold), .ref_clk(ref_clk)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_div = 1; m_duty = 2; ph = 0;
      f_lvl = 0; s_lvl = 0; run = 0; g_now = 0; g_first = 0;
    end else begin
      if (hold) begin
        f_lvl = s_lvl;
      end else if (!enable) begin
        ph = 0; f_lvl = 0; s_lvl = 0;
      end else begin
        n_len = 1 << m_div;
        h_len = (n_len * m_duty) / 2;
        f_lvl = (2 * ph) < h_len;
        s_lvl = (2 * ph + 1) < h_len;
        ph = (ph + 1) % n_len;
      end
      g_first = g_now;
      if (!hold) run = enable;
      g_now = run && !hold;
      if (!hold && !enable) begin
        m_div = int'(div_sel);
        m_duty = int'(duty_sel);
      end
    end
  end

  task automatic check(logic act, logic exp, string t);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: ref_clk=%b expected %b", t, $time, act, exp);
    end
  endtask

  always begin
    @(posedge clk); #2.5;
    if (chk_on) check(ref_clk, enable && (m_div == 0 ? g_first : f_lvl), tag);
    @(negedge clk); #2.5;
    if (chk_on) check(ref_clk, enable && (m_div == 0 ? 1'b0 : s_lvl), tag);
  end

  task automatic set_in(bit e, int d, int u, bit h);
    @(negedge clk); #3;
    enable = e; div_sel = d[2:0]; duty_sel = u[1:0]; hold = h;
  endtask

  task automatic run_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic load(int d, int u);
    set_in(0, d, u, 0);
    run_cyc(2);
  endtask

  task automatic go(int d, int u, int n);
    set_in(1, d, u, 0);
    run_cyc(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    run_cyc(2);
    chk_on = 1'b1;
    run_cyc(1);
    @(negedge clk); #3; rst = 1'b0;
    tag = "R5"; run_cyc(4);

    tag = "R1"; load(2, 2); go(2, 2, 16);
    tag = "R7"; load(3, 1); go(3, 1, 20);

    // immediate stop in the middle of a high phase
    tag = "R7"; load(2, 2);
    set_in(1, 2, 2, 0);
    @(posedge clk); @(negedge clk); #1;
    vec++;
    if (ref_clk !== 1'b1) begin
      bad++; $display("FAIL R7: start pulse ref_clk=%b expected 1", ref_clk);
    end
    #2; enable = 1'b0; #1;
    vec++;
    if (ref_clk !== 1'b0) begin
      bad++; $display("FAIL R8: after disable ref_clk=%b expected 0", ref_clk);
    end
    tag = "R8"; run_cyc(3);

    for (int d = 1; d < 8; d++) begin
      for (int u = 0; u < 4; u++) begin
        tag = (d == 1 && u[0]) ? "R4" : "R2";
        load(d, u);
        go(d, u, 2 << d);
      end
    end

    tag = "R3";
    load(0, 1); go(0, 1, 8);
    load(0, 3); go(0, 3, 8);
    load(0, 0); go(0, 0, 6);

    tag = "R6";
    load(3, 2); go(3, 2, 4);
    set_in(1, 1, 1, 0); run_cyc(20);
    set_in(0, 1, 1, 0); run_cyc(2);
    go(1, 1, 6);

    tag = "R9";
    load(3, 3); go(3, 3, 3);
    set_in(1, 3, 3, 1); run_cyc(6);
    set_in(1, 3, 3, 0); run_cyc(12);
    load(1, 1); go(1, 1, 1);
    set_in(1, 1, 1, 1); run_cyc(4);
    set_in(1, 1, 1, 0); run_cyc(6);
    load(1, 3); go(1, 3, 2);
    set_in(1, 1, 3, 1); run_cyc(3);
    set_in(1, 1, 3, 0); run_cyc(4);
    load(0, 2); go(0, 2, 3);
    set_in(1, 0, 2, 1); run_cyc(4);
    set_in(1, 0, 2, 0); run_cyc(4);

    tag = "R5";
    @(negedge clk); #3;
    rst = 1'b1; enable = 1'b1; div_sel = 3'd5; duty_sel = 2'd3;
    run_cyc(3);
    @(negedge clk); #3; rst = 1'b0;
    run_cyc(12);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule